// File: doc/BRIEF.md
# Residue Base Extension Converter

This block takes a word in a residue number system over an ordered set of pairwise coprime moduli and returns the same residues together with one additional residue for a further modulus. Downstream residue arithmetic can then work over a wider dynamic range without ever leaving the residue domain.

The new residue is found in two pipelined steps. Each incoming residue indexes its own small table. The table holds that residue multiplied by the channel's reconstruction weight, reduced modulo M, where M is the product of all moduli. A chain of registered modulo-M adders sums these partial values, which rebuilds the binary value of the word.

That binary value is then reduced modulo the extra modulus by a two-table cascade. The first table reduces the upper bit group to a residue class. The second table combines that class with the lower bit group. No single table indexed by all residues at once is needed.

The interface streams with no handshake. One word may enter on every cycle, and its result appears a fixed number of cycles later.

Top module: `rnsx_extend`

## Requirements
- R1: Each residue lane of `res_o` equals the corresponding lane of `res_i` from exactly LAT = NUM_MOD + 2 cycles earlier. Lane k carries the residue for `MODULI[k]`, and lane 0 sits in the least significant bits.
- R2: `ext_o` equals X mod EXT_MOD. Here X is the unique integer in [0, M) whose residues are the lanes of `res_i` from LAT cycles earlier, and M is the product of `MODULI`.
- R3: The latency is exactly LAT cycles. A nonzero word preceded and followed by all-zero words leaves both outputs at zero for LAT-1 cycles and shows its result on cycle LAT. Back-to-back words each yield a result on consecutive cycles.
- R4: While `rst_ni` is low, `res_o` and `ext_o` are all zeros.
- R5: The reconstruction wraps modulo M. Words near the top of the range, including X = M-1, where every lane holds modulus minus one, give the correct extra residue. The internal sums never reach M.
- R6: The moduli must be strictly increasing. Any lane input at or above its modulus is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | NUM_MOD x RES_W | Input residue lanes, lane k for MODULI[k] |
| res_o | output | NUM_MOD x RES_W | Input lanes delayed by LAT cycles |
| ext_o | output | EXT_W | Residue modulo EXT_MOD of the same word |

## Verification
A wrong table weight or a missing wrap in a modulo adder corrupts the rebuilt value. That error reaches `ext_o` exactly LAT cycles after the word that exposed it. Random words almost always expose such a fault within a handful of vectors. A misaligned delay in the adder chain mixes lanes of neighbouring words. It therefore shows up only when consecutive words differ, which a back-to-back random stream provides. An off-by-one in the pass-through delay shifts `res_o` against `ext_o`. The isolated single-word test catches this at the first sample point.

// File: rtl/rnsx_pkg.sv
package rnsx_pkg;

  // bits needed to hold 0 .. v-1
  function automatic int unsigned bits_for(int unsigned v);
    int unsigned n;
    n = 1;
    while ((longint'(1) << n) < longint'(v)) n++;
    return n;
  endfunction

  // CRT weight: (M/mi) * inverse(M/mi mod mi) mod M
  function automatic int unsigned crt_weight(int unsigned big_m, int unsigned mi);
    int unsigned rest;
    int unsigned inv;
    rest = big_m / mi;
    inv  = 0;
    for (int unsigned t = 1; t < mi; t++)
      if (((rest % mi) * t) % mi == 1) inv = t;
    return int'((longint'(rest) * longint'(inv)) % longint'(big_m));
  endfunction

endpackage

// File: rtl/rnsx_delay.sv
module rnsx_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(DEPTH); k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < int'(DEPTH); k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/rnsx_crt_lut.sv
module rnsx_crt_lut #(
  parameter int unsigned MOD_I  = 3,
  parameter int unsigned PROD_M = 30,
  parameter int unsigned RES_W  = 2,
  parameter int unsigned BIN_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] res_i,
  output logic [BIN_W-1:0] part_o
);
  localparam int unsigned WGT   = rnsx_pkg::crt_weight(PROD_M, MOD_I);
  localparam int unsigned DEPTH = 2 ** RES_W;
  localparam int unsigned TAB_W = DEPTH * BIN_W;

  function automatic logic [TAB_W-1:0] build_tab();
    logic [TAB_W-1:0] t;
    t = '0;
    for (int unsigned x = 0; x < MOD_I; x++)
      t[x*BIN_W +: BIN_W] = BIN_W'((longint'(x) * longint'(WGT)) % longint'(PROD_M));
    return t;
  endfunction

  localparam logic [TAB_W-1:0] TAB = build_tab();

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) part_o <= '0;
    else         part_o <= TAB[int'(res_i)*BIN_W +: BIN_W];
  end

  // R5
  lut_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_o < BIN_W'(PROD_M));
endmodule

// File: rtl/rnsx_mod_add.sv
module rnsx_mod_add #(
  parameter int unsigned PROD_M = 30,
  parameter int unsigned BIN_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BIN_W-1:0] a_i,
  input  logic [BIN_W-1:0] b_i,
  output logic [BIN_W-1:0] sum_o
);
  logic [BIN_W:0] raw;
  logic [BIN_W:0] wrapped;

  assign raw     = {1'b0, a_i} + {1'b0, b_i};
  assign wrapped = raw - (BIN_W+1)'(PROD_M);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           sum_o <= '0;
    else if (raw >= (BIN_W+1)'(PROD_M))    sum_o <= wrapped[BIN_W-1:0];
    else                                   sum_o <= raw[BIN_W-1:0];
  end

  // R5
  sum_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o < BIN_W'(PROD_M));
endmodule

// File: rtl/rnsx_bin2mod.sv
module rnsx_bin2mod #(
  parameter int unsigned BIN_W   = 11,
  parameter int unsigned LOW_W   = 4,
  parameter int unsigned EXT_MOD = 13,
  parameter int unsigned EXT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BIN_W-1:0] bin_i,
  output logic [EXT_W-1:0] ext_o
);
  localparam int unsigned HIGH_W = BIN_W - LOW_W;
  localparam int unsigned HI_N   = 2 ** HIGH_W;
  localparam int unsigned CB_N   = 2 ** (EXT_W + LOW_W);
  localparam int unsigned HI_TW  = HI_N * EXT_W;
  localparam int unsigned CB_TW  = CB_N * EXT_W;

  // class of the upper group: (h * 2^LOW_W) mod EXT_MOD
  function automatic logic [HI_TW-1:0] build_hi();
    logic [HI_TW-1:0] t;
    for (int unsigned h = 0; h < HI_N; h++)
      t[h*EXT_W +: EXT_W] = EXT_W'((longint'(h) << LOW_W) % longint'(EXT_MOD));
    return t;
  endfunction

  // index {class, low}: (class + low) mod EXT_MOD
  function automatic logic [CB_TW-1:0] build_cb();
    logic [CB_TW-1:0] t;
    for (int unsigned i = 0; i < CB_N; i++) begin
      int unsigned c;
      int unsigned l;
      c = i >> LOW_W;
      l = i % (2 ** LOW_W);
      t[i*EXT_W +: EXT_W] = (c < EXT_MOD) ? EXT_W'((c + l) % EXT_MOD) : '0;
    end
    return t;
  endfunction

  localparam logic [HI_TW-1:0] HI_TAB = build_hi();
  localparam logic [CB_TW-1:0] CB_TAB = build_cb();

  logic [EXT_W-1:0] cls_q;
  logic [LOW_W-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q <= '0;
      low_q <= '0;
      ext_o <= '0;
    end else begin
      cls_q <= HI_TAB[int'(bin_i[BIN_W-1:LOW_W])*EXT_W +: EXT_W];
      low_q <= bin_i[LOW_W-1:0];
      ext_o <= CB_TAB[int'({cls_q, low_q})*EXT_W +: EXT_W];
    end
  end

  // R2
  cls_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_q < EXT_W'(EXT_MOD));
  // R2
  ext_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_o < EXT_W'(EXT_MOD));
endmodule

// File: rtl/rnsx_extend.sv
module rnsx_extend #(
  parameter int unsigned NUM_MOD          = 4,
  parameter int unsigned MODULI [NUM_MOD] = '{3, 5, 7, 11},
  parameter int unsigned EXT_MOD          = 13,
  parameter int unsigned RES_W            = 4,
  parameter int unsigned EXT_W            = 4,
  parameter int unsigned LOW_W            = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_MOD-1:0][RES_W-1:0]   res_i,
  output logic [NUM_MOD-1:0][RES_W-1:0]   res_o,
  output logic [EXT_W-1:0]                ext_o
);
  function automatic int unsigned prod_all();
    int unsigned p;
    p = 1;
    for (int k = 0; k < int'(NUM_MOD); k++) p = p * MODULI[k];
    return p;
  endfunction

  localparam int unsigned PROD_M = prod_all();
  localparam int unsigned BIN_W  = rnsx_pkg::bits_for(PROD_M);
  localparam int unsigned LAT    = NUM_MOD + 2;

  // R6
  for (genvar g = 1; g < NUM_MOD; g++) begin : g_order
    if (MODULI[g] <= MODULI[g-1]) begin : g_bad
      $error("moduli must be strictly increasing");
    end
  end
  if (LOW_W >= BIN_W) begin : g_bad_low
    $error("LOW_W must be below the binary width");
  end

  logic [BIN_W-1:0] part [NUM_MOD];
  logic [BIN_W-1:0] acc  [NUM_MOD];

  for (genvar g = 0; g < NUM_MOD; g++) begin : g_lut
    rnsx_crt_lut #(
      .MOD_I (MODULI[g]),
      .PROD_M(PROD_M),
      .RES_W (RES_W),
      .BIN_W (BIN_W)
    ) u_lut (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .res_i (res_i[g]),
      .part_o(part[g])
    );

    // R6
    in_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_i[g] < RES_W'(MODULI[g]));
  end

  assign acc[0] = part[0];

  // lane j joins the chain after j-1 extra cycles
  for (genvar j = 1; j < NUM_MOD; j++) begin : g_chain
    logic [BIN_W-1:0] part_al;
    if (j == 1) begin : g_direct
      assign part_al = part[j];
    end else begin : g_align
      rnsx_delay #(.WIDTH(BIN_W), .DEPTH(j - 1)) u_align (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (part[j]),
        .q_o   (part_al)
      );
    end
    rnsx_mod_add #(.PROD_M(PROD_M), .BIN_W(BIN_W)) u_add (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (acc[j-1]),
      .b_i   (part_al),
      .sum_o (acc[j])
    );
  end

  rnsx_bin2mod #(
    .BIN_W  (BIN_W),
    .LOW_W  (LOW_W),
    .EXT_MOD(EXT_MOD),
    .EXT_W  (EXT_W)
  ) u_b2m (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bin_i (acc[NUM_MOD-1]),
    .ext_o (ext_o)
  );

  logic [NUM_MOD*RES_W-1:0] pass_d;
  logic [NUM_MOD*RES_W-1:0] pass_q;
  assign pass_d = res_i;
  assign res_o  = pass_q;

  rnsx_delay #(.WIDTH(NUM_MOD*RES_W), .DEPTH(LAT)) u_pass (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pass_d),
    .q_o   (pass_q)
  );

  // R5
  recon_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc[NUM_MOD-1] < BIN_W'(PROD_M));
endmodule

// File: tb/rnsx_extend_tb.sv
module rnsx_extend_tb_top;
  localparam int NM    = 4;
  localparam int RW    = 4;
  localparam int EW    = 4;
  localparam int EXTM  = 13;
  localparam int PM    = 3 * 5 * 7 * 11;
  localparam int LAT   = NM + 2;
  localparam int NV    = 420;
  localparam int MODS [NM] = '{3, 5, 7, 11};

  logic clk_i = 1'b0;
  logic rst_ni;
  logic [NM-1:0][RW-1:0] res_i;
  logic [NM-1:0][RW-1:0] res_o;
  logic [EW-1:0]         ext_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int xs [NV];

  always #4 clk_i = ~clk_i;

  rnsx_extend dut_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .res_i (res_i),
    .res_o (res_o),
    .ext_o (ext_o)
  );

  function automatic logic [NM-1:0][RW-1:0] to_res(int x);
    logic [NM-1:0][RW-1:0] r;
    for (int k = 0; k < NM; k++) r[k] = RW'(x % MODS[k]);
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_word(int x, string tag);
    logic [NM-1:0][RW-1:0] er;
    er = to_res(x);
    chk(res_o == er, {tag, " R1 lanes"}, int'(res_o), int'(er));
    chk(ext_o == EW'(x % EXTM), {tag, " R2 ext"}, int'(ext_o), x % EXTM);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 1'b0;
    res_i  = '0;
    repeat (3) @(negedge clk_i);
    // R4: drive nonzero during reset, outputs stay zero
    res_i = to_res(PM - 1);
    @(negedge clk_i);
    chk(res_o == '0, "R4 lanes in reset", int'(res_o), 0);
    chk(ext_o == '0, "R4 ext in reset", int'(ext_o), 0);
    res_i = '0;
    rst_ni = 1'b1;
    repeat (LAT + 1) @(negedge clk_i);
    chk(ext_o == '0 && res_o == '0, "R4 zero word after reset", int'(ext_o), 0);

    // R3: isolated word, exact latency
    res_i = to_res(PM - 1);
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk_i);
      res_i = '0;
      chk(ext_o == '0 && res_o == '0, "R3 early output", int'(ext_o), 0);
    end
    @(negedge clk_i);
    chk_word(PM - 1, "R3 R5 isolated top word");

    // directed corners then random stream, back to back (R3)
    xs[0] = 0;       xs[1] = PM - 1;  xs[2] = 1;        xs[3] = PM - 2;
    xs[4] = PM / 2;  xs[5] = EXTM;    xs[6] = PM - EXTM; xs[7] = 1024;
    xs[8] = 1023;    xs[9] = 16;      xs[10] = 15;     xs[11] = PM - 1;
    for (int i = 12; i < NV; i++) xs[i] = int'($urandom % PM);

    for (int k = 0; k < NV + LAT; k++) begin
      @(negedge clk_i);
      if (k >= LAT) chk_word(xs[k-LAT], (k - LAT < 12) ? "R5 corner" : "R3 stream");
      res_i = (k < NV) ? to_res(xs[k]) : '0;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule